// File: doc/BRIEF.md
# DDR Interleaved I/Q Deinterleaver

This block takes a 12-bit sample bus whose words alternate between the in-phase (I) and quadrature (Q) channels. It captures a word on every rising edge and on every falling edge of a port clock. The port clock always arrives as an input together with the data. The edge on which a word was captured is the only thing that decides its channel. There is no I/Q select strobe. The block rebuilds I/Q pairs and hands them out in the rising-edge domain of the port clock. Each completed pair comes with a single-cycle valid pulse.

Two configuration inputs select one of four assembly modes. One picks the edge that carries I words. The other picks whether I or Q is the earlier member of a pair. Together they fix which two captured words make up a pair. After a reset, and after any change to the configuration, the block drops words until it can form a pair in the correct order. Only then does it start to report pairs.

The output interface is a valid-only stream. A source-synchronous port cannot be stalled, so there is no ready input. The consumer must take `pair_data` on every cycle in which `pair_valid` is high. A pair that is not taken is lost when the next pair arrives.

Top module: `ddr_iq_deinterleaver`

## Requirements
- R1: A 12-bit word is captured from `din` on every rising edge and on every falling edge of `clk`. `pair_valid` and `pair_data` change only on rising edges, and at most one pair is reported per rising edge.
- R2: With `cfg_i_on_rise`=1, words captured on rising edges are I samples and words captured on falling edges are Q samples. With `cfg_i_on_rise`=0 the roles are swapped.
- R3: Number the rising edges since reset release k=0,1,2,… and call the falling edge that follows rising edge k "falling edge k". When the first member of a pair lies on a rising edge (`cfg_i_first` equal to `cfg_i_on_rise`), the pair reported after rising edge k is the rising-edge-(k-1) word together with the falling-edge-(k-1) word. Otherwise it is the falling-edge-(k-1) word together with the rising-edge-k word.
- R4: `pair_data[23:12]` holds the I sample and `pair_data[11:0]` holds the Q sample. `pair_valid` is high for exactly one cycle per pair. With a steady configuration, a pair is reported on every rising edge, in all four modes.
- R5: `rst_n` is an asynchronous, active-low reset. While it is low, `pair_valid`=0 and `pair_data`=0. After release, rising edges 0 and 1 report nothing, so the first possible pair follows rising edge 2.
- R6: A pair is reported after rising edge k only if the configuration sampled at edges k, k-1 and k-2 is identical. A configuration change therefore suppresses `pair_valid` for the two rising edges that follow the change.
- R7: `pair_data` keeps its last value on every cycle in which `pair_valid` is low.
- R8: There is no back-pressure. A pair is never held or repeated for a consumer. A new pair replaces the previous one on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source-synchronous port clock; both edges capture data |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 12 | Interleaved I/Q sample bus |
| cfg_i_first | input | 1 | 1: I is the earlier member of a pair |
| cfg_i_on_rise | input | 1 | 1: rising-edge words are I; 0: falling-edge words are I |
| pair_valid | output | 1 | One-cycle pulse per assembled pair |
| pair_data | output | 24 | {I[11:0], Q[11:0]} |

## Verification
The bench drives a different word before every edge of the clock. This exposes a design that swaps the rising and falling captures or that pairs words from the wrong cycles. Any such error shows up as scrambled I or Q fields in at least one of the four modes.

The configuration is changed on consecutive edges, and reset is asserted in the middle of a stream. These cases catch a design that reports a half-old, half-new pair, or one that asserts valid too early after reset.

Data is also compared on idle cycles. This catches an output register that loads data without a valid pulse.

// File: rtl/ddr_iq_pkg.sv
package ddr_iq_pkg;

  localparam int unsigned SAMPLE_W = 12;

  typedef struct packed {
    logic i_first;
    logic i_on_rise;
  } asm_cfg_t;

  typedef enum logic {
    SRC_EARLY = 1'b0,
    SRC_LATE  = 1'b1
  } pair_src_e;

endpackage

// File: rtl/ddr_edge_capture.sv
module ddr_edge_capture #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q
);

  // Falling-edge word, held until the next rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) fall_q <= '0;
    else        fall_q <= din;
  end

  // Rising-edge word, kept one cycle for the early pairing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rise_q <= '0;
    else        rise_q <= din;
  end

endmodule

// File: rtl/ddr_cfg_guard.sv
module ddr_cfg_guard
  import ddr_iq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  asm_cfg_t cfg_in,
  output asm_cfg_t cfg_q,
  output logic     take
);

  logic loaded;
  logic armed;
  logic mismatch;

  assign mismatch = !loaded || (cfg_in != cfg_q);
  assign take     = armed && !mismatch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      armed  <= 1'b0;
      cfg_q  <= '0;
    end else begin
      loaded <= 1'b1;
      armed  <= !mismatch;
      cfg_q  <= cfg_in;
    end
  end

endmodule

// File: rtl/ddr_pair_assembler.sv
module ddr_pair_assembler
  import ddr_iq_pkg::*;
#(
  parameter int unsigned W = 12,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  asm_cfg_t      cfg,
  input  logic          take,
  input  logic [W-1:0]  din,
  input  logic [W-1:0]  rise_q,
  input  logic [W-1:0]  fall_q,
  output logic          pair_valid,
  output logic [PW-1:0] pair_data
);

  pair_src_e    src;
  logic [W-1:0] rise_word;
  logic [W-1:0] i_word;
  logic [W-1:0] q_word;

  // First member on a rising edge: both members lie in the previous cycle
  assign src       = (cfg.i_first == cfg.i_on_rise) ? SRC_EARLY : SRC_LATE;
  assign rise_word = (src == SRC_EARLY) ? rise_q : din;
  assign i_word    = cfg.i_on_rise ? rise_word : fall_q;
  assign q_word    = cfg.i_on_rise ? fall_q : rise_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_valid <= 1'b0;
      pair_data  <= '0;
    end else begin
      pair_valid <= take;
      if (take) pair_data <= {i_word, q_word};
    end
  end

endmodule

// File: rtl/ddr_iq_deinterleaver.sv
module ddr_iq_deinterleaver
  import ddr_iq_pkg::*;
#(
  parameter int unsigned W = SAMPLE_W,
  localparam int unsigned PW = 2 * W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  din,
  input  logic          cfg_i_first,
  input  logic          cfg_i_on_rise,
  output logic          pair_valid,
  output logic [PW-1:0] pair_data
);

  asm_cfg_t     cfg_now;
  asm_cfg_t     cfg_q;
  logic         take;
  logic [W-1:0] rise_q;
  logic [W-1:0] fall_q;

  assign cfg_now = {cfg_i_first, cfg_i_on_rise};

  ddr_edge_capture #(.W(W)) u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (din),
    .rise_q (rise_q),
    .fall_q (fall_q)
  );

  ddr_cfg_guard u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .cfg_in (cfg_now),
    .cfg_q  (cfg_q),
    .take   (take)
  );

  ddr_pair_assembler #(.W(W)) u_assemble (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg_q),
    .take       (take),
    .din        (din),
    .rise_q     (rise_q),
    .fall_q     (fall_q),
    .pair_valid (pair_valid),
    .pair_data  (pair_data)
  );

endmodule

// File: rtl/ddr_iq_deinterleaver_chk.sv
module ddr_iq_deinterleaver_chk #(
  parameter int unsigned PW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_i_first,
  input logic          cfg_i_on_rise,
  input logic          pair_valid,
  input logic [PW-1:0] pair_data
);

  logic [1:0] cfg_bits;
  assign cfg_bits = {cfg_i_first, cfg_i_on_rise};

  // R5: outputs are cleared while reset is held
  a_r5_reset_clear: assert property (@(posedge clk)
    !rst_n |-> (!pair_valid && pair_data == '0));

  // R5: no pair before two settling edges after release
  a_r5_settle: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(rst_n) && $past(rst_n, 2)));

  // R6: a configuration change blanks the next two outputs
  a_r6_blank_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits != $past(cfg_bits)) |=> !pair_valid);

  a_r6_blank_second: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits != $past(cfg_bits)) |=> ##1 !pair_valid);

  // R6: a reported pair was built under one configuration
  a_r6_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> ($past(cfg_bits) == $past(cfg_bits, 2)));

  // R7: data holds on idle cycles
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_valid |-> $stable(pair_data));

endmodule

bind ddr_iq_deinterleaver ddr_iq_deinterleaver_chk #(.PW(PW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_i_first   (cfg_i_first),
  .cfg_i_on_rise (cfg_i_on_rise),
  .pair_valid    (pair_valid),
  .pair_data     (pair_data)
);

// File: tb/test_ddr_iq_deinterleaver.sv
module test_ddr_iq_deinterleaver;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic [11:0] din = '0;
  logic        ci_first = 1'b0;
  logic        ci_rise = 1'b0;
  logic        pair_valid;
  logic [23:0] pair_data;

  int vectors = 0;
  int fails = 0;
  int cnt = 0;
  bit done = 0;
  bit pat_ph = 0;
  logic [23:0] held = '0;

  logic [11:0] rw [0:4095];
  logic [11:0] fw [0:4095];
  logic [1:0]  cf [0:4095];

  always #2.5 clk = ~clk;

  ddr_iq_deinterleaver i_ddr_iq_deinterleaver (
    .clk           (clk),
    .rst_n         (rst_n),
    .din           (din),
    .cfg_i_first   (ci_first),
    .cfg_i_on_rise (ci_rise),
    .pair_valid    (pair_valid),
    .pair_data     (pair_data)
  );

  function automatic logic [11:0] next_word(input bit pat);
    if (pat) begin
      pat_ph = ~pat_ph;
      return pat_ph ? 12'hFFF : 12'h000;
    end
    return 12'($urandom);
  endfunction

  task automatic step(input logic [1:0] c_next, input bit rst_next, input bit pat);
    logic [11:0] cur_r;
    logic [11:0] rise_w;
    logic [11:0] fall_w;
    bit ev;
    logic [23:0] ed;
    int j;
    string tag;
    cur_r = din;
    j = cnt;
    @(posedge clk); #1;
    vectors++;
    if (!rst_n) begin
      ev = 0; ed = '0; held = '0; tag = "R5";
    end else begin
      rw[j] = cur_r;
      cf[j] = {ci_first, ci_rise};
      ev = (j >= 2) && (cf[j] == cf[j-1]) && (cf[j-1] == cf[j-2]);
      tag = (j < 2) ? "R5" : (ev ? "R4" : "R6");
      if (ev) begin
        // R3: pair membership; R2: channel by edge
        fall_w = fw[j-1];
        if (cf[j][1] == cf[j][0]) rise_w = rw[j-1];
        else                      rise_w = rw[j];
        ed = cf[j][0] ? {rise_w, fall_w} : {fall_w, rise_w};
        held = ed;
      end else begin
        ed = held;
      end
    end
    if (pair_valid !== ev) begin
      fails++;
      $display("FAIL %s edge %0d valid: actual %b expected %b", tag, j, pair_valid, ev);
    end
    if (pair_data !== ed) begin
      fails++;
      $display("FAIL %s edge %0d data: actual %h expected %h",
               ev ? "R3" : (rst_n ? "R7" : "R5"), j, pair_data, ed);
    end
    din = next_word(pat);
    if (rst_n) begin
      fw[j] = din;
      cnt++;
    end
    @(negedge clk); #1;
    din = next_word(pat);
    {ci_first, ci_rise} = c_next;
    if (!rst_next) cnt = 0;
    rst_n = rst_next;
  endtask

  task automatic run(input logic [1:0] c, input int n, input bit pat);
    for (int i = 0; i < n; i++) step(c, 1'b1, pat);
  endtask

  initial begin
    logic [1:0] c;
    #1 rst_n = 1'b0;
    @(negedge clk); #1;
    // R5: reset state
    for (int i = 0; i < 3; i++) step(2'b11, 1'b0, 1'b0);
    step(2'b11, 1'b1, 1'b0);
    // R1 R2 R3 R4: all four modes, continuous stream
    run(2'b11, 30, 1'b0);
    run(2'b10, 30, 1'b0);
    run(2'b01, 30, 1'b0);
    run(2'b00, 30, 1'b0);
    // R6 R7: configuration changes, some back to back
    c = 2'b00;
    for (int i = 0; i < 60; i++) begin
      if (i % 4 == 0 || i > 45) c = 2'($urandom);
      step(c, 1'b1, 1'b0);
    end
    // R5 R8: reset in the middle of a stream
    for (int i = 0; i < 3; i++) step(2'b01, 1'b0, 1'b0);
    step(2'b01, 1'b1, 1'b0);
    run(2'b01, 20, 1'b0);
    // R2: alternating all-ones / all-zeros words
    run(2'b10, 16, 1'b1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule